// File: doc/BRIEF.md
# Descriptor-Chain DMA Source Engine

This block is the read side of a DMA engine. It pulls data out of memory and hands it to a downstream consumer as a stream of 32-bit words. It has two ways of working, and one bit of the mode register selects between them.

- **Direct mode** copies one contiguous buffer. The buffer is set by a start-address register and a byte-count register.
- **Chain mode** walks a list of descriptors held in memory. Each descriptor takes four consecutive words: buffer address, byte count, address of the following descriptor, and a flags word. Bit 31 of the flags word closes the chain.

A transfer starts when software writes the mode register with the enable bit set while the engine is idle. The engine then issues word reads on a request/grant memory port, with one read outstanding at a time. It presents each word on a valid/ready stream, together with a count of how many low-order bytes of the word carry payload.

The transfer ends in one of two ways:
- When the last word has been accepted downstream, the engine pulses a completion event and clears the enable bit. The consumer may still be working on that data.
- If any read returns an error response, the walk stops at once. The engine pulses an error event instead of the completion event and clears the enable bit.

Top module: `desc_dma_walker`

## Requirements
- R1: After reset the engine is idle: `engineBusy`, `memReq`, `outValid`, `srcDone` and `rdErr` are all low.
- R2: A write to select 0 (mode) starts a transfer only when data bit 31 is set and the engine is idle. A write with bit 31 clear does not start one. `engineBusy` reflects the enable bit, and `outValid` and `memReq` are only ever high while it is set.
- R3: With mode bit 25 clear (direct mode), the engine reads ceil(N/4) words at A, A+4, A+8 and so on. A is the value written to select 1 and N is the value written to select 2.
- R4: With mode bit 25 set (chain mode), the first descriptor sits at the address written to select 3. Its four words are read at offsets +0, +4, +8 and +12, in that order: buffer address, byte count, next-descriptor address, flags.
- R5: A descriptor whose flags bit 31 is set is the last one. Any other descriptor is followed by fetching the descriptor at its next-descriptor address. Flag bits other than bit 31 have no effect.
- R6: A descriptor with a byte count of 0 issues no data reads. The engine goes straight to the completion check or to the next descriptor. A direct transfer with size 0 completes without any read.
- R7: Each output word is the memory word as read. `outBytes` is 4, except for a buffer's final word, where it is the remainder (1 to 3). The payload sits in the low bytes. While `outValid` is high and `outReady` is low, `outData` and `outBytes` hold steady.
- R8: After the final word of the final buffer is accepted, `srcDone` pulses for one cycle. In that same cycle `engineBusy` is already low.
- R9: A read answered with `memRerr` ends the transfer. No further reads or words follow, `rdErr` pulses for one cycle instead of `srcDone`, and the enable bit clears.
- R10: While the engine is busy, writes to every select are ignored. A later transfer uses the values written before it started.
- R11: At most one read is outstanding. After a grant, `memReq` stays low until the read data has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 mode, 1 direct address, 2 direct size, 3 first descriptor |
| regWdata | input | 32 | Register write data |
| engineBusy | output | 1 | Enable bit of the mode register |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Word-aligned read address |
| memGnt | input | 1 | Request accepted |
| memRvalid | input | 1 | Read data returned |
| memRdata | input | 32 | Read data |
| memRerr | input | 1 | Error response, qualified by `memRvalid` |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer accepts the word |
| outData | output | 32 | Output word |
| outBytes | output | 3 | Number of valid low-order bytes (1 to 4) |
| srcDone | output | 1 | One-cycle pulse: all data delivered |
| rdErr | output | 1 | One-cycle pulse: a read returned an error |

## Verification
The bench runs a set of transfers and checks each one as it happens.

- **Direct buffer of ten bytes.** This checks address stepping and the two-byte tail word.
- **Direct transfer of size 0.** This tells a correct empty completion apart from a spurious read.
- **Three-descriptor chain with a zero-length middle entry and stray flag bits.** This separates chain following, skipping an empty descriptor, and honouring only bit 31.
- **Single three-byte descriptor, and a terminating descriptor of size 0.** These cover the partial-only and data-free endings.
- **Error responses on a data word and on a descriptor word.** These show that the walk stops at the exact read that failed.
- **Register writes during a busy chain walk, then a mode write with enable clear.** These show that mid-transfer writes are ignored and that a write without the enable bit does not start the engine.

Grant spacing, read latency and consumer back-pressure change from run to run. This shows the stream order does not depend on handshake timing.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WORD_W  = 32;
  localparam int BYTES_W = 3;

  // register selects
  localparam logic [1:0] SEL_MODE     = 2'd0;
  localparam logic [1:0] SEL_SRCADDR  = 2'd1;
  localparam logic [1:0] SEL_SRCSIZE  = 2'd2;
  localparam logic [1:0] SEL_FIRSTDSC = 2'd3;

  // mode and flag bit positions
  localparam int MODE_EN_BIT   = 31;
  localparam int MODE_LIST_BIT = 25;
  localparam int FLAG_LAST_BIT = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_BREQ, ST_BWAIT, ST_EMIT, ST_NEXT
  } walkState_t;

  typedef struct packed {
    logic startList;
    logic startDirect;
    logic selDesc;
    logic loadDesc;
    logic followNext;
    logic loadBeat;
    logic beatTaken;
    logic finish;
  } walkStrobe_t;
endpackage

// File: rtl/dmaw_datapath.sv
module dmaw_datapath
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [WORD_W-1:0]  regWdata,
  input  walkStrobe_t        strb,
  input  logic [WORD_W-1:0]  memRdata,
  output logic               modeEn,
  output logic               modeList,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [WORD_W-1:0]  outData,
  output logic [BYTES_W-1:0] outBytes,
  output logic               remainZero,
  output logic               lastDesc,
  output logic               descWordLast
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int               BEAT_BYTES = WORD_W / 8;
  localparam logic [LEN_W-1:0] BEAT_LEN   = LEN_W'(BEAT_BYTES);

  logic [ADDR_W-1:0]  directAddr, firstDesc, descPtr, curAddr, nextPtr, rawAddr;
  logic [LEN_W-1:0]   directSize, remain;
  logic [1:0]         wordIdx;
  logic               lastFlag;
  logic [WORD_W-1:0]  beatData;
  logic [BYTES_W-1:0] beatBytes;
  logic               cfgWrite;

  assign cfgWrite = regWe && !modeEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEn     <= 1'b0;
      modeList   <= 1'b0;
      directAddr <= '0;
      directSize <= '0;
      firstDesc  <= '0;
    end else begin
      if (strb.finish) modeEn <= 1'b0;
      else if (cfgWrite && regSel == SEL_MODE) begin
        modeEn   <= regWdata[MODE_EN_BIT];
        modeList <= regWdata[MODE_LIST_BIT];
      end
      if (cfgWrite && regSel == SEL_SRCADDR)  directAddr <= regWdata[ADDR_W-1:0];
      if (cfgWrite && regSel == SEL_SRCSIZE)  directSize <= regWdata[LEN_W-1:0];
      if (cfgWrite && regSel == SEL_FIRSTDSC) firstDesc  <= regWdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr   <= '0;
      wordIdx   <= '0;
      curAddr   <= '0;
      remain    <= '0;
      nextPtr   <= '0;
      lastFlag  <= 1'b0;
      beatData  <= '0;
      beatBytes <= '0;
    end else begin
      if (strb.startList) begin
        descPtr <= firstDesc;
        wordIdx <= '0;
      end
      if (strb.startDirect) begin
        curAddr  <= directAddr;
        remain   <= directSize;
        lastFlag <= 1'b1;
      end
      if (strb.loadDesc) begin
        case (wordIdx)
          2'd0:    curAddr  <= memRdata[ADDR_W-1:0];
          2'd1:    remain   <= memRdata[LEN_W-1:0];
          2'd2:    nextPtr  <= memRdata[ADDR_W-1:0];
          default: lastFlag <= memRdata[FLAG_LAST_BIT];
        endcase
        wordIdx <= wordIdx + 2'd1;
      end
      if (strb.followNext) begin
        descPtr <= nextPtr;
        wordIdx <= '0;
      end
      if (strb.loadBeat) begin
        beatData  <= memRdata;
        beatBytes <= (remain >= BEAT_LEN) ? BYTES_W'(BEAT_BYTES) : BYTES_W'(remain);
      end
      if (strb.beatTaken) begin
        remain  <= remain - LEN_W'(beatBytes);
        curAddr <= curAddr + ADDR_W'(BEAT_BYTES);
      end
    end
  end

  assign rawAddr      = strb.selDesc ? descPtr + ADDR_W'({wordIdx, 2'b00}) : curAddr;
  assign memAddr      = {rawAddr[ADDR_W-1:2], 2'b00};
  assign outData      = beatData;
  assign outBytes     = beatBytes;
  assign remainZero   = (remain == '0);
  assign lastDesc     = lastFlag;
  assign descWordLast = (wordIdx == 2'd3);

  // R10: configuration is frozen while a transfer runs
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && regWe) |=> ($stable(directAddr) && $stable(directSize) && $stable(firstDesc)));
endmodule

// File: rtl/dmaw_control.sv
module dmaw_control
  import dmaw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        startList,
  input  logic        memGnt,
  input  logic        memRvalid,
  input  logic        memRerr,
  input  logic        outReady,
  input  logic        remainZero,
  input  logic        lastDesc,
  input  logic        descWordLast,
  output walkStrobe_t strb,
  output logic        memReq,
  output logic        outValid,
  output logic        srcDone,
  output logic        rdErr
);
  timeunit 1ns;
  timeprecision 1ps;

  walkState_t state, stateNext;
  logic doneSet, errSet;

  always_comb begin
    stateNext = state;
    strb      = '0;
    memReq    = 1'b0;
    outValid  = 1'b0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        if (startList) begin
          strb.startList = 1'b1;
          stateNext      = ST_DREQ;
        end else begin
          strb.startDirect = 1'b1;
          stateNext        = ST_NEXT;
        end
      end
      ST_DREQ: begin
        strb.selDesc = 1'b1;
        memReq       = 1'b1;
        if (memGnt) stateNext = ST_DWAIT;
      end
      ST_DWAIT: begin
        strb.selDesc = 1'b1;
        if (memRvalid) begin
          if (memRerr) begin
            strb.finish = 1'b1;
            errSet      = 1'b1;
            stateNext   = ST_IDLE;
          end else begin
            strb.loadDesc = 1'b1;
            stateNext     = descWordLast ? ST_NEXT : ST_DREQ;
          end
        end
      end
      ST_BREQ: begin
        memReq = 1'b1;
        if (memGnt) stateNext = ST_BWAIT;
      end
      ST_BWAIT: if (memRvalid) begin
        if (memRerr) begin
          strb.finish = 1'b1;
          errSet      = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          strb.loadBeat = 1'b1;
          stateNext     = ST_EMIT;
        end
      end
      ST_EMIT: begin
        outValid = 1'b1;
        if (outReady) begin
          strb.beatTaken = 1'b1;
          stateNext      = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (!remainZero) stateNext = ST_BREQ;
        else if (lastDesc) begin
          strb.finish = 1'b1;
          doneSet     = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          strb.followNext = 1'b1;
          stateNext       = ST_DREQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      srcDone <= 1'b0;
      rdErr   <= 1'b0;
    end else begin
      state   <= stateNext;
      srcDone <= doneSet;
      rdErr   <= errSet;
    end
  end

  // R6: an exhausted buffer never leads to a data read
  a_r6_no_read_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NEXT && remainZero) |=> (state != ST_BREQ));
endmodule

// File: rtl/desc_dma_walker.sv
module desc_dma_walker
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [WORD_W-1:0]  regWdata,
  output logic               engineBusy,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memGnt,
  input  logic               memRvalid,
  input  logic [WORD_W-1:0]  memRdata,
  input  logic               memRerr,
  output logic               outValid,
  input  logic               outReady,
  output logic [WORD_W-1:0]  outData,
  output logic [BYTES_W-1:0] outBytes,
  output logic               srcDone,
  output logic               rdErr
);
  timeunit 1ns;
  timeprecision 1ps;

  walkStrobe_t strb;
  logic modeEn, modeList, remainZero, lastDesc, descWordLast, startReq;

  assign startReq   = regWe && (regSel == SEL_MODE) && regWdata[MODE_EN_BIT] && !modeEn;
  assign engineBusy = modeEn;

  dmaw_control u_control (
    .clk, .rstN, .startReq,
    .startList(regWdata[MODE_LIST_BIT]),
    .memGnt, .memRvalid, .memRerr, .outReady,
    .remainZero, .lastDesc, .descWordLast,
    .strb, .memReq, .outValid, .srcDone, .rdErr
  );

  dmaw_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_datapath (
    .clk, .rstN, .regWe, .regSel, .regWdata, .strb, .memRdata,
    .modeEn, .modeList, .memAddr, .outData, .outBytes,
    .remainZero, .lastDesc, .descWordLast
  );

  // R2: activity only while enabled
  a_r2_active_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || memReq) |-> engineBusy);
  // R7: a stalled word is held
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outBytes)));
  // R7: byte qualifier range
  a_r7_bytes_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outBytes != 3'd0 && outBytes <= 3'd4));
  // R8: completion leaves the engine idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    srcDone |-> (!engineBusy && !outValid && !memReq));
  // R9: the two end events never coincide
  a_r9_single_event: assert property (@(posedge clk) disable iff (!rstN)
    !(srcDone && rdErr));
  // R11: one read in flight
  a_r11_single_read: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt) |=> !memReq);
endmodule

// File: tb/desc_dma_walker_bench.sv
module desc_dma_walker_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWdata = 32'd0;
  logic        engineBusy, memReq, outValid, srcDone, rdErr;
  logic [31:0] memAddr, outData;
  logic [2:0]  outBytes;
  logic        memGnt = 1'b0, memRvalid = 1'b0, memRerr = 1'b0, outReady = 1'b0;
  logic [31:0] memRdata = 32'd0;

  always #4 clk = ~clk;  // 125 MHz

  desc_dma_walker u_desc_dma_walker (
    .clk, .rstN, .regWe, .regSel, .regWdata, .engineBusy,
    .memReq, .memAddr, .memGnt, .memRvalid, .memRdata, .memRerr,
    .outValid, .outReady, .outData, .outBytes, .srcDone, .rdErr
  );

  int unsigned memImg[int unsigned];
  bit          badAddr[int unsigned];
  int unsigned expAddrQ[$];
  logic [31:0] expDataQ[$];
  int          expBytesQ[$];
  int          expEvent = 0;  // 1 done, 2 error
  bit          evSeen = 0;
  int          checks = 0, failures = 0, cyc = 0;
  int          gntMod = 1, latency = 1, readyMode = 0, pend = 0;
  bit          outstanding = 0;
  int unsigned lastAddr = 0;

  function automatic logic [31:0] memWord(int unsigned a);
    if (memImg.exists(a)) return memImg[a];
    return (a * 32'd2654435761) ^ 32'h5a5a0f0f;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic planData(int unsigned addr, int unsigned len, output bit hitErr);
    hitErr = 0;
    while (len > 0) begin
      int unsigned b;
      expAddrQ.push_back(addr);
      if (badAddr.exists(addr)) begin hitErr = 1; return; end
      b = (len >= 4) ? 4 : len;
      expDataQ.push_back(memWord(addr));
      expBytesQ.push_back(int'(b));
      len -= b;
      addr += 4;
    end
  endtask

  task automatic planDirect(int unsigned addr, int unsigned len);
    bit e;
    planData(addr, len, e);
    expEvent = e ? 2 : 1;
  endtask

  task automatic planList(int unsigned ptr);
    expEvent = 1;
    for (int n = 0; n < 16; n++) begin
      logic [31:0] w[4];
      bit e;
      for (int k = 0; k < 4; k++) begin
        expAddrQ.push_back(ptr + 4 * k);
        if (badAddr.exists(ptr + 4 * k)) begin expEvent = 2; return; end
        w[k] = memWord(ptr + 4 * k);
      end
      planData(w[0], w[1], e);
      if (e) begin expEvent = 2; return; end
      if (w[3][31]) return;
      ptr = w[2];
    end
  endtask

  task automatic setDesc(int unsigned at, int unsigned a, int unsigned l, int unsigned nx, int unsigned fl);
    memImg[at] = a; memImg[at + 4] = l; memImg[at + 8] = nx; memImg[at + 12] = fl;
  endtask

  task automatic regWrite(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = s; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitEnd(string tag);
    for (int i = 0; i < 3000 && !evSeen; i++) @(posedge clk);
    @(negedge clk);
    #2;
    check(evSeen, {tag, " end event seen"}, 32'(evSeen), 32'd1);
    check(!engineBusy, {tag, " enable cleared"}, 32'(engineBusy), 32'd0);
    check(expAddrQ.size() == 0 && expDataQ.size() == 0, {tag, " all expected traffic seen"},
          32'(expAddrQ.size() + expDataQ.size()), 32'd0);
    evSeen = 0;
    expEvent = 0;
  endtask

  // memory responder, consumer and cycle-by-cycle comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      memGnt = 1'b0; memRvalid = 1'b0; memRerr = 1'b0;
      if (outstanding) begin
        if (memReq) check(0, "R11 request while read outstanding", 32'd1, 32'd0);
        pend--;
        if (pend == 0) begin
          memRvalid = 1'b1;
          memRdata  = memWord(lastAddr);
          memRerr   = badAddr.exists(lastAddr);
          outstanding = 0;
        end
      end else if (rstN && memReq && (cyc % gntMod) == 0) begin
        memGnt = 1'b1;
        lastAddr = memAddr;
        outstanding = 1;
        pend = latency;
        if (expAddrQ.size() == 0) check(0, "R3/R4 unexpected read", memAddr, 32'd0);
        else begin
          int unsigned e;
          e = expAddrQ.pop_front();
          check(memAddr == e, "R3/R4 read address order", memAddr, e);
        end
      end
      outReady = (readyMode == 0) ? 1'b1 :
                 (readyMode == 1) ? ((cyc % 3) != 0) : ((cyc % 5) >= 3);
      #1;
      if (rstN && outValid && outReady) begin
        if (expDataQ.size() == 0) check(0, "R7 unexpected output word", outData, 32'd0);
        else begin
          logic [31:0] d;
          int b;
          d = expDataQ.pop_front();
          b = expBytesQ.pop_front();
          check(outData == d, "R7 output word", outData, d);
          check(outBytes == b[2:0], "R7 byte qualifier", 32'(outBytes), 32'(b));
        end
      end
      if (rstN && srcDone) begin
        evSeen = 1;
        check(expEvent == 1, "R8 done event expected", 32'd1, 32'(expEvent));
        check(expDataQ.size() == 0, "R8 done only after last word", 32'(expDataQ.size()), 32'd0);
        check(!engineBusy, "R8 enable low with done", 32'(engineBusy), 32'd0);
      end
      if (rstN && rdErr) begin
        evSeen = 1;
        check(expEvent == 2, "R9 error event expected", 32'd2, 32'(expEvent));
        check(!srcDone, "R9 no done with error", 32'(srcDone), 32'd0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    #2;
    check(!engineBusy && !memReq && !outValid && !srcDone && !rdErr, "R1 reset state",
          {27'd0, engineBusy, memReq, outValid, srcDone, rdErr}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // direct ten bytes
    planDirect(32'h1000, 10);
    regWrite(2'd1, 32'h1000);
    regWrite(2'd2, 32'd10);
    regWrite(2'd0, 32'h8000_0000);
    waitEnd("R3 direct ten bytes");

    // direct zero size
    planDirect(32'h1800, 0);
    regWrite(2'd1, 32'h1800);
    regWrite(2'd2, 32'd0);
    regWrite(2'd0, 32'h8000_0000);
    waitEnd("R6 direct zero size");

    // chain of three with empty middle, stray flag bits
    setDesc(32'h100, 32'h2000, 8, 32'h200, 32'h4000_0001);
    setDesc(32'h200, 32'h3000, 0, 32'h300, 32'h0000_0000);
    setDesc(32'h300, 32'h4000, 5, 32'h0,   32'h8000_0000);
    gntMod = 2; latency = 2; readyMode = 1;
    planList(32'h100);
    regWrite(2'd3, 32'h100);
    regWrite(2'd0, 32'hF200_0000);
    waitEnd("R4 R5 chain of three");

    // single partial descriptor
    setDesc(32'h400, 32'h5000, 3, 32'hDEAD_0000, 32'h8000_0000);
    gntMod = 1; latency = 3; readyMode = 2;
    planList(32'h400);
    regWrite(2'd3, 32'h400);
    regWrite(2'd0, 32'h8200_0000);
    waitEnd("R7 single partial");

    // terminating empty descriptor
    setDesc(32'h500, 32'h6000, 0, 32'h0, 32'h8000_0000);
    planList(32'h500);
    regWrite(2'd3, 32'h500);
    regWrite(2'd0, 32'h8200_0000);
    waitEnd("R6 empty last descriptor");

    // data read error
    setDesc(32'h600, 32'h7000, 12, 32'h0, 32'h8000_0000);
    badAddr[32'h7004] = 1;
    latency = 1; readyMode = 0;
    planList(32'h600);
    regWrite(2'd3, 32'h600);
    regWrite(2'd0, 32'h8200_0000);
    waitEnd("R9 data read error");

    // descriptor read error
    setDesc(32'h800, 32'h7100, 4, 32'h0, 32'h8000_0000);
    badAddr[32'h808] = 1;
    planList(32'h800);
    regWrite(2'd3, 32'h800);
    regWrite(2'd0, 32'h8200_0000);
    waitEnd("R9 descriptor read error");

    // writes while busy are ignored
    regWrite(2'd1, 32'hA000);
    regWrite(2'd2, 32'd8);
    gntMod = 3; latency = 2;
    planList(32'h100);
    regWrite(2'd3, 32'h100);
    regWrite(2'd0, 32'h8200_0000);
    regWrite(2'd2, 32'd40);
    regWrite(2'd1, 32'hB000);
    regWrite(2'd0, 32'h8000_0000);
    regWrite(2'd3, 32'h500);
    waitEnd("R10 chain with busy writes");
    gntMod = 1;
    planDirect(32'hA000, 8);
    regWrite(2'd0, 32'h8000_0000);
    waitEnd("R10 direct uses earlier config");

    // enable clear: no start
    regWrite(2'd0, 32'h0200_0000);
    repeat (10) @(negedge clk);
    #2;
    check(!engineBusy && !outValid, "R2 no start without enable",
          {30'd0, engineBusy, outValid}, 32'd0);
    check(!evSeen, "R2 no event without enable", 32'(evSeen), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule